// File: doc/BRIEF.md
# Double Precision Compare Unit

This block compares two 64-bit IEEE-754 double-precision words and returns a 64-bit truth word along with two exception flags. A 4-bit function code selects one of four predicates: unordered, equal, less-than or less-or-equal. A caller presents both operands, the function code and a flush control on a valid strobe. One clock later the unit returns a registered result and a matching valid strobe.

The result follows the floating-point register convention rather than the integer one. Truth is the word with only bit 62 set, and falsehood is all zeros. Quiet NaNs are tolerated by the equality and unordered predicates but raise invalid on the two ordering predicates. Signalling NaNs raise invalid on every predicate. A subnormal operand always raises the denormal flag. With flush enabled, a subnormal compares as a zero of its own sign.

Top module: `fcmp64_unit`

## Requirements
- R1: Function code 4 selects unordered, 5 selects equal, 6 selects less-than (A below B) and 7 selects less-or-equal. Any other code yields a zero result with both flags clear.
- R2: A true result is exactly 0x4000000000000000 (only bit 62 set). A false result is 0x0000000000000000.
- R3: Unordered is true exactly when at least one operand is a NaN, meaning its exponent field (bits 62:52) is 0x7FF and its fraction (bits 51:0) is nonzero.
- R4: Equal, less-than and less-or-equal follow IEEE ordering. Positive and negative zero compare equal, infinities order at the extremes, and all three predicates are false when either operand is a NaN.
- R5: With a NaN operand, invalid is raised for codes 6 and 7 in every case. For codes 4 and 5 it is raised only when an operand is a signalling NaN, meaning fraction bit 51 is clear.
- R6: The denormal flag is raised for codes 4 to 7 whenever an operand has a zero exponent and a nonzero fraction, whatever the flush input.
- R7: With flush_dn high, a subnormal operand is compared as a zero carrying its own sign bit. With flush_dn low, it is compared by its true value.
- R8: out_valid rises in the cycle after in_valid is sampled high. Result and flags change only on a sampled strobe and otherwise hold.
- R9: While rst_n is low at a clock edge, out_valid, result and both flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and function code are valid this cycle |
| func | input | 4 | Predicate selector (4 unordered, 5 equal, 6 less-than, 7 less-or-equal) |
| flush_dn | input | 1 | Treat subnormal operands as signed zeros |
| op_a | input | 64 | First operand, double-precision bit pattern |
| op_b | input | 64 | Second operand, double-precision bit pattern |
| out_valid | output | 1 | Result and flags are valid this cycle |
| result | output | 64 | Truth word: 0x4000000000000000 or zero |
| flag_invalid | output | 1 | Invalid-operation exception |
| flag_denorm | output | 1 | Subnormal-input exception |

## Verification
The bench builds the unit with its default parameters: an 11-bit exponent, a 52-bit fraction and truth placed at bit 62. This is the only shape under which the fixed double-precision bit patterns in its vector table mean what they say. At that size the vectors reach every boundary that matters for this unit:
- signed zeros against each other;
- the smallest subnormal against zero and the smallest normal, with flush both off and on;
- quiet and signalling NaNs on either side, infinities, and negative magnitudes whose ordering inverts;
- undefined function codes on either side of the legal range.

// File: rtl/fcmp_pkg.sv
// Shared widths, function encodings and the per-operand class record
// used by the double-precision compare unit.
package fcmp_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = EXP_W + FRAC_W;
    localparam int FUNC_W = 4;

    typedef enum logic [FUNC_W-1:0] {
        FN_UNORD = 4'd4,
        FN_EQ    = 4'd5,
        FN_LT    = 4'd6,
        FN_LE    = 4'd7
    } cmp_fn_e;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             snan;
        logic             denorm;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } opnd_class_t;
endpackage

// File: rtl/fcmp_classify.sv
// Classifies one double-precision operand: NaN, signalling NaN, subnormal
// and zero. Also forms the magnitude used for ordering.
// Assumes: with flush set, a subnormal's fraction is replaced by zero
// and its sign is kept.
module fcmp_classify
    import fcmp_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              flush_i,
    output opnd_class_t       cls_o
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic [FRAC_W-1:0] frac_eff;
    logic              is_sub;

    assign exp_f  = word_i[WORD_W-2 -: EXP_W];
    assign frac_f = word_i[FRAC_W-1:0];

    // Derive the class bits and the effective magnitude of the operand.
    always_comb begin
        is_sub       = (exp_f == '0) && (frac_f != '0);
        frac_eff     = (flush_i && is_sub) ? '0 : frac_f;
        cls_o.sign   = word_i[WORD_W-1];
        cls_o.nan    = (&exp_f) && (frac_f != '0);
        cls_o.snan   = cls_o.nan && !frac_f[FRAC_W-1];
        cls_o.denorm = is_sub;
        cls_o.zero   = (exp_f == '0) && (frac_eff == '0);
        cls_o.mag    = {exp_f, frac_eff};
    end
endmodule

// File: rtl/fcmp_relate.sv
// Relates two classified operands: unordered, equal, A strictly below B.
// Assumes: magnitudes are sign-magnitude patterns whose unsigned order
// matches numeric order for non-NaN values of one sign.
module fcmp_relate
    import fcmp_pkg::*;
(
    input  logic             a_sign_i,
    input  logic             a_nan_i,
    input  logic             a_zero_i,
    input  logic [MAG_W-1:0] a_mag_i,
    input  logic             b_sign_i,
    input  logic             b_nan_i,
    input  logic             b_zero_i,
    input  logic [MAG_W-1:0] b_mag_i,
    output logic             unord_o,
    output logic             eq_o,
    output logic             lt_o
);
    logic both_zero;
    logic mag_lt;
    logic mag_gt;
    logic sign_lt;

    // Decide the ordering relation with signed zeros folded together.
    always_comb begin
        both_zero = a_zero_i && b_zero_i;
        mag_lt    = a_mag_i < b_mag_i;
        mag_gt    = a_mag_i > b_mag_i;
        unord_o   = a_nan_i || b_nan_i;
        if (a_sign_i != b_sign_i)
            sign_lt = a_sign_i;
        else if (a_sign_i)
            sign_lt = mag_gt;
        else
            sign_lt = mag_lt;
        eq_o = !unord_o && (both_zero ||
               ((a_sign_i == b_sign_i) && (a_mag_i == b_mag_i)));
        lt_o = !unord_o && !both_zero && sign_lt;
    end
endmodule

// File: rtl/fcmp_decide.sv
// Selects the predicate named by the function code and forms the
// invalid and denormal flags for it.
// Assumes: codes outside the four predicates give false with no flags.
module fcmp_decide
    import fcmp_pkg::*;
(
    input  logic [FUNC_W-1:0] func_i,
    input  logic              unord_i,
    input  logic              eq_i,
    input  logic              lt_i,
    input  logic              any_snan_i,
    input  logic              any_sub_i,
    output logic              truth_o,
    output logic              inv_o,
    output logic              dn_o
);
    // Map the selected predicate to truth and exception outputs.
    always_comb begin
        truth_o = 1'b0;
        inv_o   = 1'b0;
        dn_o    = any_sub_i;
        case (func_i)
            FN_UNORD: begin
                truth_o = unord_i;
                inv_o   = unord_i && any_snan_i;
            end
            FN_EQ: begin
                truth_o = eq_i;
                inv_o   = unord_i && any_snan_i;
            end
            FN_LT: begin
                truth_o = lt_i;
                inv_o   = unord_i;
            end
            FN_LE: begin
                truth_o = lt_i || eq_i;
                inv_o   = unord_i;
            end
            default: dn_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fcmp64_unit.sv
// Double-precision compare unit: one registered stage that evaluates
// unordered, equal, less-than or less-or-equal on two operands.
// Assumes: synchronous active-low reset; outputs hold between strobes.
module fcmp64_unit
    import fcmp_pkg::*;
#(
    parameter int TRUE_POS = 62
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [FUNC_W-1:0]    func,
    input  logic                 flush_dn,
    input  logic [WORD_W-1:0]    op_a,
    input  logic [WORD_W-1:0]    op_b,
    output logic                 out_valid,
    output logic [WORD_W-1:0]    result,
    output logic                 flag_invalid,
    output logic                 flag_denorm
);
    localparam logic [WORD_W-1:0] TRUE_WORD = WORD_W'(1) << TRUE_POS;
    localparam int N_OPND = 2;

    logic [WORD_W-1:0] opnd [N_OPND];
    opnd_class_t       cls  [N_OPND];
    logic unord, eq, lt, truth, inv, dn;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar i = 0; i < N_OPND; i++) begin : g_cls
        fcmp_classify u_cls (
            .word_i  (opnd[i]),
            .flush_i (flush_dn),
            .cls_o   (cls[i])
        );
    end

    fcmp_relate u_rel (
        .a_sign_i (cls[0].sign),
        .a_nan_i  (cls[0].nan),
        .a_zero_i (cls[0].zero),
        .a_mag_i  (cls[0].mag),
        .b_sign_i (cls[1].sign),
        .b_nan_i  (cls[1].nan),
        .b_zero_i (cls[1].zero),
        .b_mag_i  (cls[1].mag),
        .unord_o  (unord),
        .eq_o     (eq),
        .lt_o     (lt)
    );

    fcmp_decide u_dec (
        .func_i     (func),
        .unord_i    (unord),
        .eq_i       (eq),
        .lt_i       (lt),
        .any_snan_i (cls[0].snan || cls[1].snan),
        .any_sub_i  (cls[0].denorm || cls[1].denorm),
        .truth_o    (truth),
        .inv_o      (inv),
        .dn_o       (dn)
    );

    // Register the outcome on a strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_denorm  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result       <= truth ? TRUE_WORD : '0;
                flag_invalid <= inv;
                flag_denorm  <= dn;
            end
        end
    end
endmodule

// File: rtl/fcmp64_checker.sv
// Protocol and outcome properties for the compare unit, bound to its
// top module. NaN detection here is computed from the ports.
module fcmp64_checker
    import fcmp_pkg::*;
#(
    parameter int TRUE_POS = 62
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [FUNC_W-1:0] func,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              flag_invalid,
    input logic              flag_denorm
);
    localparam logic [WORD_W-1:0] TRUE_WORD = WORD_W'(1) << TRUE_POS;

    logic a_nan, b_nan, legal_fn;
    assign a_nan = (&op_a[WORD_W-2 -: EXP_W]) && (op_a[FRAC_W-1:0] != '0);
    assign b_nan = (&op_b[WORD_W-2 -: EXP_W]) && (op_b[FRAC_W-1:0] != '0);
    assign legal_fn = (func >= 4'd4) && (func <= 4'd7);

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flag_invalid) && $stable(flag_denorm)));
    p_encoding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (result == '0) || (result == TRUE_WORD));
    p_unord_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(func) == 4'd4) |-> ((result != '0) == ($past(a_nan) || $past(b_nan))));
    p_order_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(func) == 4'd6 || $past(func) == 4'd7) && ($past(a_nan) || $past(b_nan)))
        |-> (flag_invalid && result == '0));
    p_eq_nan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(func) == 4'd5 && ($past(a_nan) || $past(b_nan))) |-> (result == '0));
    p_undef_fn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(legal_fn)) |-> (result == '0 && !flag_invalid && !flag_denorm));
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0 && !flag_invalid && !flag_denorm));
endmodule

bind fcmp64_unit fcmp64_checker #(.TRUE_POS(TRUE_POS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .func         (func),
    .op_a         (op_a),
    .op_b         (op_b),
    .out_valid    (out_valid),
    .result       (result),
    .flag_invalid (flag_invalid),
    .flag_denorm  (flag_denorm)
);

// File: tb/fcmp64_unit_test.sv
`timescale 1ns/1ps
module fcmp64_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  func = 4'd0;
    logic        flush_dn = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        flag_invalid;
    logic        flag_denorm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [63:0] TRUE_W = 64'h4000000000000000;
    localparam logic [63:0] P1 = 64'h3FF0000000000000, P2 = 64'h4000000000000000;
    localparam logic [63:0] M1 = 64'hBFF0000000000000, M2 = 64'hC000000000000000;
    localparam logic [63:0] PZ = 64'h0, MZ = 64'h8000000000000000;
    localparam logic [63:0] PI = 64'h7FF0000000000000, MI = 64'hFFF0000000000000;
    localparam logic [63:0] QN = 64'h7FF8000000000000, SN = 64'h7FF0000000000001;
    localparam logic [63:0] PD = 64'h0000000000000001, MD = 64'h8000000000000001;
    localparam logic [63:0] MN = 64'h0010000000000000;

    // Vector layout: {func[4], flush, true, invalid, denorm, a[64], b[64]}
    localparam int NV = 28;
    localparam logic [135:0] VEC [NV] = '{
        {4'd4, 1'b0, 1'b0, 1'b0, 1'b0, P1, P2},  // R3 ordered
        {4'd4, 1'b0, 1'b1, 1'b0, 1'b0, QN, P1},  // R3 quiet NaN
        {4'd4, 1'b0, 1'b1, 1'b1, 1'b0, P1, SN},  // R3 R5 signalling
        {4'd5, 1'b0, 1'b1, 1'b0, 1'b0, P1, P1},  // R4
        {4'd5, 1'b0, 1'b1, 1'b0, 1'b0, PZ, MZ},  // R4 signed zeros
        {4'd5, 1'b0, 1'b0, 1'b0, 1'b0, QN, QN},  // R5 quiet no invalid
        {4'd5, 1'b0, 1'b0, 1'b1, 1'b0, P1, SN},  // R5
        {4'd5, 1'b0, 1'b0, 1'b1, 1'b0, SN, SN},  // R5
        {4'd5, 1'b0, 1'b0, 1'b0, 1'b0, P1, P2},  // R4
        {4'd6, 1'b0, 1'b1, 1'b0, 1'b0, P1, P2},  // R4
        {4'd6, 1'b0, 1'b0, 1'b0, 1'b0, P2, P1},  // R4
        {4'd6, 1'b0, 1'b1, 1'b0, 1'b0, M1, P1},  // R4
        {4'd6, 1'b0, 1'b1, 1'b0, 1'b0, M2, M1},  // R4 negative order
        {4'd6, 1'b0, 1'b1, 1'b0, 1'b0, MI, PI},  // R4 infinities
        {4'd6, 1'b0, 1'b0, 1'b1, 1'b0, QN, P1},  // R5
        {4'd6, 1'b0, 1'b0, 1'b0, 1'b0, PZ, MZ},  // R4
        {4'd7, 1'b0, 1'b1, 1'b0, 1'b0, P1, P1},  // R4
        {4'd7, 1'b0, 1'b0, 1'b0, 1'b0, P2, P1},  // R4
        {4'd7, 1'b0, 1'b0, 1'b1, 1'b0, P1, QN},  // R5
        {4'd7, 1'b0, 1'b1, 1'b0, 1'b0, MZ, PZ},  // R4
        {4'd7, 1'b0, 1'b1, 1'b0, 1'b0, PI, PI},  // R4
        {4'd5, 1'b0, 1'b0, 1'b0, 1'b1, PD, PZ},  // R6 R7 no flush
        {4'd5, 1'b1, 1'b1, 1'b0, 1'b1, PD, PZ},  // R7 flush
        {4'd6, 1'b0, 1'b1, 1'b0, 1'b1, MD, PZ},  // R7 no flush
        {4'd6, 1'b1, 1'b0, 1'b0, 1'b1, MD, PZ},  // R7 flush to -0
        {4'd6, 1'b1, 1'b1, 1'b0, 1'b1, PD, MN},  // R7
        {4'd3, 1'b0, 1'b0, 1'b0, 1'b0, P1, P1},  // R1 below range
        {4'd8, 1'b1, 1'b0, 1'b0, 1'b0, QN, PD}   // R1 above range
    };

    fcmp64_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .func(func),
        .flush_dn(flush_dn), .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
        .result(result), .flag_invalid(flag_invalid), .flag_denorm(flag_denorm)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Present one compare and check the outcome one cycle later.
    task automatic run(input logic [3:0] f, input logic fl, input logic [63:0] a,
                       input logic [63:0] b, input bit t, input bit inv, input bit dn);
        string rq;
        logic [63:0] exp_r;
        if (f < 4'd4 || f > 4'd7) rq = "R1";
        else if (f == 4'd4) rq = "R3";
        else if (fl) rq = "R7";
        else rq = "R4";
        exp_r = t ? TRUE_W : 64'h0;
        @(negedge clk);
        func = f; flush_dn = fl; op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        op_a = ~a; op_b = ~b;
        check(out_valid == 1'b1, "R8", "out_valid", 64'(out_valid), 64'h1);
        check(result == exp_r, rq, "result (R2 encoding)", result, exp_r);
        check(flag_invalid == inv, "R5", "invalid", 64'(flag_invalid), 64'(inv));
        check(flag_denorm == dn, "R6", "denorm", 64'(flag_denorm), 64'(dn));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && result == '0 && !flag_invalid && !flag_denorm,
              "R9", "reset state", result, 64'h0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++)
            run(VEC[i][135:132], VEC[i][131], VEC[i][127:64], VEC[i][63:0],
                VEC[i][130], VEC[i][129], VEC[i][128]);
        // R8: strobe dropped, outputs hold the last true-with-flags result
        run(4'd4, 1'b0, SN, PD, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "valid drops", 64'(out_valid), 64'h0);
        check(result == TRUE_W && flag_invalid && flag_denorm, "R8", "hold",
              result, TRUE_W);
        // R9: reset clears a loaded result
        rst_n = 1'b0;
        @(negedge clk);
        check(result == '0 && !flag_invalid && !flag_denorm && !out_valid,
              "R9", "reset clears", result, 64'h0);
        rst_n = 1'b1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule